// File: doc/BRIEF.md
# Two-Column Weighted Bit Counter

This block adds up the ones in two neighbouring columns of a dot matrix. One column carries bits of weight one and the other carries bits of weight two. It returns the weighted total as a 4-bit binary number, with one result bit in each of four consecutive columns. It is purely combinational. It is meant as a building cell wherever a small group of bits from two adjacent ranks must collapse into a single compact binary value.

A parameter selects the shape of the cell:

- two columns of five bits each;
- six low-weight bits with four high-weight bits;
- a single column of ten equal-weight bits, in which case the high-weight port is present but unused.

The shape is checked during elaboration. It is rejected when the largest possible weighted total cannot be written in the output width. The counting itself is done by chains of full adders, not by a behavioural population count.

Top module: `weighted_counter`

## Requirements
- R1: With the six-and-four shape, `in_w1` is 6 bits of weight 1, `in_w2` is 4 bits of weight 2, and `cnt` equals the number of ones in `in_w1` plus twice the number of ones in `in_w2`.
- R2: With the five-and-five shape (the default), `in_w1` and `in_w2` are each 5 bits, and `cnt` equals ones(`in_w1`) + 2 × ones(`in_w2`).
- R3: With the single-column shape, `in_w1` is 10 bits of equal weight, and `cnt` equals the number of ones among them.
- R4: With the single-column shape, the 1-bit `in_w2` port has no effect on `cnt`.
- R5: Bit 0 of `cnt` always equals the XOR of all bits of `in_w1`, because weight-2 bits never reach column 0.
- R6: All inputs zero gives `cnt` = 0. All used inputs one gives the shape's maximum: 15 for five-and-five, 14 for six-and-four, 10 for single-column.
- R7: `cnt` never wraps; it never exceeds the shape's maximum weighted total, which never exceeds 2^OUT_W − 1. A shape that breaks this bound fails elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_w1 | input | N_W1 (5, 6 or 10) | Bits of weight 1 |
| in_w2 | input | N_W2P (5, 4 or 1) | Bits of weight 2; ignored in the single-column shape |
| cnt | output | OUT_W (4) | Weighted count in binary |

## Verification
All three shapes are built side by side. Each is driven with every combination of its used input bits. This exposes any per-column miscount as well as any mix-up of the two weights, since swapping the weights changes the total whenever the two columns hold different numbers of ones.

The single-column build also sees every vector once with its spare high-weight bit set. This separates a correct count from one that leaks that bit into the result.

The all-zero and all-ones patterns pin the extremes of each shape. A parity comparison on bit 0 separates a correct low column from one where weight-2 bits were misplaced into column 0.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

  typedef enum logic [1:0] {
    SHAPE_5_5  = 2'd0,
    SHAPE_6_4  = 2'd1,
    SHAPE_10   = 2'd2
  } shape_e;

  function automatic int w1_bits(shape_e s);
    case (s)
      SHAPE_6_4: return 6;
      SHAPE_10:  return 10;
      default:   return 5;
    endcase
  endfunction

  function automatic int w2_bits(shape_e s);
    case (s)
      SHAPE_6_4: return 4;
      SHAPE_10:  return 0;
      default:   return 5;
    endcase
  endfunction

  function automatic int max_weight(shape_e s);
    return w1_bits(s) + 2 * w2_bits(s);
  endfunction

endpackage

// File: rtl/wpc_fa.sv
module wpc_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (a & ci) | (b & ci);
endmodule

// File: rtl/wpc_rca.sv
// Ripple adder; the top slice keeps only its sum because the
// compression rule guarantees no carry leaves the word.
module wpc_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s
);
  logic [W-1:0] c;
  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_slice
    if (i < W - 1) begin : g_full
      wpc_fa u_fa (.a(a[i]), .b(b[i]), .ci(c[i]), .s(s[i]), .co(c[i+1]));
    end else begin : g_top
      assign s[i] = a[i] ^ b[i] ^ c[i];
    end
  end
endmodule

// File: rtl/wpc_col_count.sv
// Counts the ones of one column by feeding each bit as the carry-in
// of a chained adder stage.
module wpc_col_count #(
  parameter int N  = 5,
  parameter int CW = 4
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);
  logic [CW-1:0] acc [0:N];
  assign acc[0] = '0;

  for (genvar k = 0; k < N; k++) begin : g_stage
    wpc_rca #(.W(CW)) u_inc (
      .a  (acc[k]),
      .b  ({CW{1'b0}}),
      .ci (bits[k]),
      .s  (acc[k+1])
    );
  end

  assign count = acc[N];
endmodule

// File: rtl/weighted_counter.sv
module weighted_counter #(
  parameter wpc_pkg::shape_e SHAPE = wpc_pkg::SHAPE_5_5,
  parameter int OUT_W = 4,
  localparam int N_W1  = wpc_pkg::w1_bits(SHAPE),
  localparam int N_W2  = wpc_pkg::w2_bits(SHAPE),
  localparam int N_W2P = (N_W2 > 0) ? N_W2 : 1
) (
  input  logic [N_W1-1:0]  in_w1,
  input  logic [N_W2P-1:0] in_w2,
  output logic [OUT_W-1:0] cnt
);
  localparam int MAXW = wpc_pkg::max_weight(SHAPE);
  localparam int HI_W = OUT_W - 1;

  if (MAXW > (2 ** OUT_W) - 1) begin : g_bad_shape
    $error("weighted_counter: shape total %0d exceeds output range", MAXW);
  end

  logic [OUT_W-1:0] lo_cnt;
  logic [HI_W-1:0]  hi_cnt;

  wpc_col_count #(.N(N_W1), .CW(OUT_W)) u_lo (
    .bits  (in_w1),
    .count (lo_cnt)
  );

  if (N_W2 > 0) begin : g_hi
    wpc_col_count #(.N(N_W2), .CW(HI_W)) u_hi (
      .bits  (in_w2),
      .count (hi_cnt)
    );
  end else begin : g_no_hi
    logic spare_unused;
    assign spare_unused = ^in_w2;
    assign hi_cnt = '0;
  end

  wpc_rca #(.W(OUT_W)) u_merge (
    .a  (lo_cnt),
    .b  ({hi_cnt, 1'b0}),
    .ci (1'b0),
    .s  (cnt)
  );
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker #(
  parameter wpc_pkg::shape_e SHAPE = wpc_pkg::SHAPE_5_5,
  parameter int OUT_W = 4,
  localparam int N_W1  = wpc_pkg::w1_bits(SHAPE),
  localparam int N_W2  = wpc_pkg::w2_bits(SHAPE),
  localparam int N_W2P = (N_W2 > 0) ? N_W2 : 1
) (
  input logic [N_W1-1:0]  in_w1,
  input logic [N_W2P-1:0] in_w2,
  input logic [OUT_W-1:0] cnt
);
  localparam int MAXW = wpc_pkg::max_weight(SHAPE);

  int ones_lo, ones_hi;
  always_comb begin
    ones_lo = $countones(in_w1);
    ones_hi = (N_W2 > 0) ? $countones(in_w2) : 0;
    if (!$isunknown({in_w1, in_w2, cnt})) begin
      // R1, R2, R3, R4: weighted total of the used bits only
      assert_weighted_sum_R2: assert (int'(cnt) == ones_lo + 2 * ones_hi);
      assert_lsb_parity_R5: assert (cnt[0] == ^in_w1);
      assert_no_overflow_R7: assert (int'(cnt) <= MAXW);
      if (ones_lo == 0 && ones_hi == 0)
        assert_zero_R6: assert (cnt == '0);
      if (ones_lo == N_W1 && ones_hi == N_W2)
        assert_full_R6: assert (int'(cnt) == MAXW);
    end
  end
endmodule

bind weighted_counter wpc_checker #(.SHAPE(SHAPE), .OUT_W(OUT_W)) u_chk (
  .in_w1 (in_w1),
  .in_w2 (in_w2),
  .cnt   (cnt)
);

// File: tb/weighted_counter_test.sv
module weighted_counter_test;
  logic clk;
  logic rst_n;
  int   n_checks = 0;
  int   n_fail   = 0;
  int   cyc      = 0;
  bit   done     = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [4:0] a_w1, a_w2;
  logic [5:0] b_w1;
  logic [3:0] b_w2;
  logic [9:0] c_w1;
  logic [0:0] c_w2;
  logic [3:0] a_cnt, b_cnt, c_cnt;

  weighted_counter #(.SHAPE(wpc_pkg::SHAPE_5_5)) uut (
    .in_w1(a_w1), .in_w2(a_w2), .cnt(a_cnt));
  weighted_counter #(.SHAPE(wpc_pkg::SHAPE_6_4)) uut_64 (
    .in_w1(b_w1), .in_w2(b_w2), .cnt(b_cnt));
  weighted_counter #(.SHAPE(wpc_pkg::SHAPE_10)) uut_10 (
    .in_w1(c_w1), .in_w2(c_w2), .cnt(c_cnt));

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(int v);
    a_w1 = v[4:0];  a_w2 = v[9:5];
    b_w1 = v[5:0];  b_w2 = v[9:6];
    c_w1 = v[9:0];  c_w2 = v[10];
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 reset zero 5,5", int'(a_cnt), 0);
    check("R6 reset zero 6,4", int'(b_cnt), 0);
    check("R6 reset zero 10",  int'(c_cnt), 0);
    rst_n = 1'b1;

    for (int v = 0; v < 2048; v++) begin
      @(posedge clk);
      #1 drive(v);
      @(negedge clk);
      begin
        int ea, eb, ec;
        ea = $countones(v[4:0]) + 2 * $countones(v[9:5]);
        eb = $countones(v[5:0]) + 2 * $countones(v[9:6]);
        ec = $countones(v[9:0]);
        check("R2 sum 5,5", int'(a_cnt), ea);
        check("R1 sum 6,4", int'(b_cnt), eb);
        if (v[10]) check("R4 spare ignored 10", int'(c_cnt), ec);
        else       check("R3 sum 10", int'(c_cnt), ec);
        check("R5 parity 5,5", int'(a_cnt[0]), $countones(v[4:0]) % 2);
        check("R5 parity 6,4", int'(b_cnt[0]), $countones(v[5:0]) % 2);
        check("R7 bound 6,4", int'(int'(b_cnt) <= 14), 1);
        check("R7 bound 10", int'(int'(c_cnt) <= 10), 1);
      end
    end

    @(posedge clk);
    #1 drive(2047);
    @(negedge clk);
    check("R6 full 5,5", int'(a_cnt), 15);
    check("R6 full 6,4", int'(b_cnt), 14);
    check("R6 full 10",  int'(c_cnt), 10);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule